// File: doc/BRIEF.md
# Successive-Approximation Conversion Bus Controller

This block runs the digital side of an 8-bit successive-approximation converter and connects its result to a microprocessor bus. A processor pulls chip select and the start strobe low to request a conversion. The block then resolves the code one bit at a time, starting with the most significant bit. For each bit it drives a trial code to an external ladder and reads back a single comparator decision. When every bit is decided, the block stores the code in an output register and pulls an active-low interrupt low.

A read strobe with chip select low clears the interrupt and puts the stored code on the data pins, with an enable that says when those pins are driven. A new start request during a conversion abandons it and restarts from the beginning. A conversion that is abandoned never changes the stored code. If chip select and read are held low and the interrupt is fed back to the start input, the block converts continuously. This loop needs one forced low start pulse to get going.

All strobes pass through a two-flop synchronizer. A conversion does not begin at the falling edge of a request. It begins only after the request is released, once a free-running 3-bit phase counter reaches its final value.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After synchronous reset, intr_n is 1, result_q is 0, trial_code is 0, and data_oe is 0 while rd_n is high.
- R2: While the synchronized cs_n and wr_n are both low, the block holds its reset state: trial_code is 0 and intr_n is 1.
- R3: The first trial code (value 0x80) appears 1 to 8 clocks after the synchronized release of the start request. This is 4 to 11 bench samples after the input wr_n rises.
- R4: Bits are resolved MSB first. Each bit is held on trial_code for a settle clock and then kept only if cmp_hi (input at or above trial_code) is 1. The final code equals the largest code that is not above the analog level.
- R5: intr_n goes low in the same clock that result_q takes the new code, at most 74 clocks after wr_n is released.
- R6: With cs_n low, a low rd_n drives data_oe to 1, puts result_q on data_out and returns intr_n to 1. With cs_n high, rd_n has no effect.
- R7: A new start request during a conversion aborts it. result_q keeps the last completed code, and the new conversion then completes with the new value.
- R8: With cs_n and rd_n held low and wr_n tied to intr_n, one forced low start pulse makes the block convert repeatedly, and result_q follows the analog level.
- R9: The interrupt is set high only by a read or by a start request. A completed conversion that nobody reads leaves intr_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Start strobe, active low |
| rd_n | input | 1 | Output-enable/read strobe, active low |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above trial_code |
| trial_code | output | 8 | Trial code driven to the ladder |
| result_q | output | 8 | Output latch holding the last completed code |
| data_out | output | 8 | Data bus value, valid while data_oe is 1 |
| data_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| intr_n | output | 1 | Conversion-complete interrupt, active low |

## Verification
The bench builds the block with its defaults: an 8-bit code, two synchronizer stages and a 3-bit phase counter. With these values the full range of start delays (1 to 8 clocks) occurs across repeated starts. The code extremes 0x00 and 0xFF, the mid-scale boundary values 0x80 and 0x7F, and an alternating pattern exercise every keep/clear decision. A two-stage pipeline keeps an abort that lands in the middle of the bit sequence well ahead of the final decision, so the retained latch value can be observed before the restart completes.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic rd_n;
    } strobe_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_JUDGE  = 3'd4
    } eng_state_e;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1};

endpackage

// File: rtl/sar_strobe_sync.sv
module sar_strobe_sync
    import sar_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t raw,
    output strobe_t clean
);
    strobe_t pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe[s] <= STROBE_IDLE;
                end else if (s == 0) begin
                    pipe[s] <= raw;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign clean = pipe[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int PH_BITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial,
    output logic             done,
    output logic [WIDTH-1:0] code
);
    localparam logic [PH_BITS-1:0] PH_LAST = '1;
    localparam int                 WC_BITS = PH_BITS + 1;
    localparam logic [WC_BITS-1:0] WC_LIM  = WC_BITS'(1 << PH_BITS);
    localparam logic [WIDTH-1:0]   TOP_BIT = WIDTH'(1) << (WIDTH - 1);

    eng_state_e         st;
    logic [WIDTH-1:0]   tq;
    logic [WIDTH-1:0]   mask;
    logic [PH_BITS-1:0] phase;
    logic [WC_BITS-1:0] wcnt;
    logic [WIDTH-1:0]   decided;

    // keep the trial bit when the input is at or above the trial level
    always_comb begin
        decided = cmp_hi ? tq : (tq & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            tq   <= '0;
            mask <= '0;
            wcnt <= '0;
        end else if (hold) begin
            st   <= ST_HOLD;
            tq   <= '0;
            mask <= '0;
            wcnt <= '0;
        end else begin
            unique case (st)
                ST_HOLD: begin
                    st   <= ST_WAIT;
                    wcnt <= '0;
                end
                ST_WAIT: begin
                    if (phase == PH_LAST) begin
                        st   <= ST_SETTLE;
                        tq   <= TOP_BIT;
                        mask <= TOP_BIT;
                        wcnt <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    st <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    tq   <= decided | (mask >> 1);
                    mask <= mask >> 1;
                    st   <= mask[0] ? ST_IDLE : ST_SETTLE;
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    assign trial = tq;
    assign done  = (st == ST_JUDGE) && mask[0] && !hold;
    assign code  = decided;

    // R4
    bit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE || st == ST_JUDGE) |-> ($countones(mask) == 1));

    // R4
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETTLE) |-> ((tq & (mask - 1'b1)) == '0));

    // R3
    start_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT) |-> (wcnt < WC_LIM));
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PH_BITS     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] result_q,
    output logic [WIDTH-1:0] data_out,
    output logic             data_oe,
    output logic             intr_n
);
    strobe_t          raw_s;
    strobe_t          cln_s;
    logic             hold;
    logic             rd_req;
    logic             done;
    logic [WIDTH-1:0] code;

    assign raw_s = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n};

    sar_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw_s),
        .clean (cln_s)
    );

    assign hold   = !cln_s.cs_n && !cln_s.wr_n;
    assign rd_req = !cln_s.cs_n && !cln_s.rd_n;

    sar_engine #(.WIDTH(WIDTH), .PH_BITS(PH_BITS)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .cmp_hi (cmp_hi),
        .trial  (trial_code),
        .done   (done),
        .code   (code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
        end else if (done) begin
            result_q <= code;
        end
    end

    // start request clears, completion sets, read clears unless a result lands
    always_ff @(posedge clk) begin
        if (rst) begin
            intr_n <= 1'b1;
        end else if (hold) begin
            intr_n <= 1'b1;
        end else if (done) begin
            intr_n <= 1'b0;
        end else if (rd_req) begin
            intr_n <= 1'b1;
        end
    end

    assign data_oe  = rd_req;
    assign data_out = rd_req ? result_q : '0;

    // R2
    hold_intr_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> intr_n);

    // R5
    intr_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(intr_n) |-> $past(done));

    // R7
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result_q));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !done) |=> intr_n);

    // R9
    intr_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!intr_n && !hold && !rd_req) |=> !intr_n);
endmodule

// File: tb/sar_bus_ctrl_tb.sv
module sar_bus_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, wr_drv, rd_n;
    logic       free_mode, force_lo;
    logic       wr_pin;
    logic [7:0] vin;
    logic       cmp_hi;
    logic [7:0] trial_code, result_q, data_out;
    logic       data_oe, intr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    // analog front end model: comparator against the trial code
    assign cmp_hi = (vin >= trial_code);
    assign wr_pin = free_mode ? (force_lo ? 1'b0 : intr_n) : wr_drv;

    sar_bus_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .wr_n       (wr_pin),
        .rd_n       (rd_n),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code),
        .result_q   (result_q),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .intr_n     (intr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // start, check hold state, release, measure delay and completion
    task automatic convert(input logic [7:0] level);
        int cnt;
        int tot;
        vin = level;
        @(negedge clk);
        cs_n = 1'b0; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        chk(trial_code == 8'h00, "R2 trial in hold", trial_code, 0);
        chk(intr_n == 1'b1, "R2 intr in hold", intr_n, 1);
        wr_drv = 1'b1; cs_n = 1'b1;
        cnt = 0;
        while (trial_code == 8'h00 && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        // 2 sync edges + HOLD->WAIT edge + 1..8 wait clocks => 4..11 samples
        chk(cnt >= 4 && cnt <= 11, "R3 start delay", cnt, 4);
        chk(trial_code == 8'h80, "R3 first trial", trial_code, 8'h80);
        tot = cnt;
        while (intr_n == 1'b1 && tot < 80) begin
            @(negedge clk);
            tot++;
        end
        chk(tot <= 74, "R5 completion time", tot, 74);
        chk(intr_n == 1'b0, "R5 intr low", intr_n, 0);
        chk(result_q == level, "R4 result", result_q, level);
    endtask

    task automatic do_read(input logic [7:0] exp);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_oe == 1'b1, "R6 oe on read", data_oe, 1);
        chk(data_out == exp, "R6 data on read", data_out, exp);
        chk(intr_n == 1'b1, "R6 intr cleared", intr_n, 1);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(data_oe == 1'b0, "R6 oe released", data_oe, 0);
    endtask

    task automatic test_reset();
        chk(intr_n == 1'b1, "R1 intr", intr_n, 1);
        chk(result_q == 8'h00, "R1 result", result_q, 0);
        chk(trial_code == 8'h00, "R1 trial", trial_code, 0);
        chk(data_oe == 1'b0, "R1 oe", data_oe, 0);
    endtask

    task automatic test_patterns();
        logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h7F};
        foreach (pats[i]) begin
            convert(pats[i]);
            do_read(pats[i]);
        end
    endtask

    task automatic test_unread_and_deselected_read();
        convert(8'hA5);
        repeat (20) @(negedge clk);
        chk(intr_n == 1'b0, "R9 intr stays low unread", intr_n, 0);
        rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(data_oe == 1'b0, "R6 read ignored with cs high", data_oe, 0);
        chk(intr_n == 1'b0, "R6 intr kept with cs high", intr_n, 0);
        rd_n = 1'b1;
        do_read(8'hA5);
    endtask

    task automatic test_abort();
        int cnt;
        vin = 8'h3C;
        @(negedge clk);
        cs_n = 1'b0; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        wr_drv = 1'b1; cs_n = 1'b1;
        cnt = 0;
        while (trial_code == 8'h00 && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        repeat (5) @(negedge clk);
        vin = 8'hC3;
        cs_n = 1'b0; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        chk(result_q == 8'hA5, "R7 latch kept on abort", result_q, 8'hA5);
        chk(intr_n == 1'b1, "R7 no completion on abort", intr_n, 1);
        wr_drv = 1'b1; cs_n = 1'b1;
        cnt = 0;
        while (intr_n == 1'b1 && cnt < 80) begin
            @(negedge clk);
            cnt++;
        end
        chk(result_q == 8'hC3, "R7 restart result", result_q, 8'hC3);
        do_read(8'hC3);
    endtask

    task automatic test_free_run();
        int falls;
        logic prev;
        vin = 8'h33;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; free_mode = 1'b1; force_lo = 1'b1;
        repeat (3) @(negedge clk);
        force_lo = 1'b0;
        falls = 0;
        prev = intr_n;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (prev && !intr_n) falls++;
            prev = intr_n;
        end
        chk(falls >= 4, "R8 repeated conversions", falls, 4);
        chk(result_q == 8'h33, "R8 first level", result_q, 8'h33);
        vin = 8'hC4;
        repeat (150) @(negedge clk);
        chk(result_q == 8'hC4, "R8 follows level", result_q, 8'hC4);
        chk(data_out == 8'hC4 && data_oe, "R8 bus shows level", data_out, 8'hC4);
        free_mode = 1'b0; wr_drv = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; wr_drv = 1'b1; rd_n = 1'b1;
        free_mode = 1'b0; force_lo = 1'b0; vin = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_patterns();
        test_unread_and_deselected_read();
        test_abort();
        test_free_run();
        finish_up();
    end
endmodule